// File: doc/BRIEF.md
# Integer Math Unit with Status Flags

This block is a 16-bit signed integer arithmetic unit for a controller datapath. On a one-cycle start pulse it runs one of five operations on two two's-complement operands: add, subtract, multiply, divide, and a double-width divide whose dividend is the block's own 32-bit math register. Each operation writes a 16-bit destination result and a carry, overflow, zero and sign flag, and follows its own rule for each flag.

Multiply and both divides also leave a full-precision result in the math register, which is seen as a high word and a low word. After a multiply the register holds the 32-bit product. After a divide it holds the truncated quotient in the high word and the remainder in the low word. The double-width divide reads that register as its dividend, so a multiply followed by a double-width divide gives a scaled ratio.

Add, subtract and multiply finish in a single cycle. The two divides run a restoring shift-and-subtract sequence, one quotient bit per cycle, and hold `busy` high while it runs. Any overflow or division by zero also sets a sticky error bit, which only an explicit clear removes.

Top module: `int_math_unit`

## Requirements
- R1: `op_code` selects the operation: 0 add, 1 subtract, 2 multiply, 3 divide, 4 double-width divide. A start with code 5, 6 or 7 is ignored: `done` and `busy` stay low, and the result, the flags and the math register keep their values.
- R2: Add writes `dest` = (src_a + src_b) mod 2^16. `flag_c` is the unsigned carry out of bit 15. `flag_v` is set when two operands of the same sign give a result of the other sign. The math register is unchanged.
- R3: Subtract writes `dest` = (src_a − src_b) mod 2^16. `flag_c` is set on a borrow (src_a < src_b taken as unsigned). `flag_v` is set when operands of different signs give a result whose sign differs from src_a. The math register is unchanged.
- R4: After every completed operation, overflow cases included, `flag_z` is 1 exactly when `dest` is 0, and `flag_s` equals bit 15 of `dest`.
- R5: Multiply always clears `flag_c` and always loads {`mreg_hi`,`mreg_lo`} with the full 32-bit signed product. When the product lies outside −32768..32767, `flag_v` is set and `dest` saturates to 0x7FFF (positive product) or 0x8000 (negative product). Otherwise `dest` is the product.
- R6: Divide (src_a / src_b, src_b ≠ 0) clears `flag_c`. `dest` is the exact quotient rounded half away from zero. `mreg_hi` gets the quotient truncated toward zero and `mreg_lo` the remainder, which carries the sign of the dividend. `done` rises 18 clock edges after the edge that samples start.
- R7: Divide with quotient overflow (−32768 / −1) sets `flag_v`, writes `dest` = 0x7FFF and leaves the math register unchanged.
- R8: The double-width divide takes the signed 32-bit {`mreg_hi`,`mreg_lo`} as dividend and src_a as divisor. It writes the truncated quotient to `dest` and `mreg_hi` and the dividend-signed remainder to `mreg_lo`. When the quotient lies outside −32768..32767, it sets `flag_v`, saturates `dest` to 0x7FFF or 0x8000 by the quotient's sign and leaves the math register unchanged. `done` rises 34 edges after the start edge.
- R9: Division by zero (divide with src_b = 0, or the double-width divide with src_a = 0) completes after one edge. It sets `flag_v`, clears `flag_c`, writes `dest` = 0x7FFF for a non-negative dividend and 0x8001 for a negative one, and leaves the math register unchanged.
- R10: `minor_err` is set by any completion with `flag_v` = 1. It stays set until `err_clr` is high at an edge where no overflowing completion happens. A set and a clear at the same edge leave it set.
- R11: While a divide runs, `busy` is high and any start is ignored: the running result is unaffected and no extra `done` follows. `busy` is low in the cycle `done` is high.
- R12: After reset `dest`, the math register, all flags, `minor_err`, `busy` and `done` are all 0.
- R13: `done` is a single-cycle pulse. Add, subtract and multiply raise it one edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle command strobe, taken only while idle |
| op_code | input | 3 | Operation select (see R1) |
| src_a | input | 16 | Signed operand A (dividend for divide, divisor for double-width divide) |
| src_b | input | 16 | Signed operand B |
| err_clr | input | 1 | Clears the sticky error bit |
| busy | output | 1 | A divide sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| dest | output | 16 | Destination result |
| mreg_hi | output | 16 | Math register high word |
| mreg_lo | output | 16 | Math register low word |
| flag_c | output | 1 | Carry / borrow flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| minor_err | output | 1 | Sticky overflow / divide-by-zero error |

## Verification
The assertions rely on the top never loading the divider with a zero divisor; the divide-by-zero path exists to make that true. They also rely on the remainder staying below the divisor magnitude at every iteration. They take `start` as a one-cycle strobe whose operands only matter at the edge where it is accepted. The stimulus pulses start once per command and waits for `busy` to fall before the next one, except in the test that deliberately strobes during a divide. Operands cover the signed extremes, including −32768 as dividend, divisor and multiplicand, so the magnitude and saturation corners fall within what the properties cover.

// File: rtl/imu_pkg.sv
package imu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_DIV = 3'd3,
    OP_DDV = 3'd4
  } imu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } imu_state_e;

  localparam logic [2:0] OP_LAST = 3'd4;

endpackage

// File: rtl/imu_fast_path.sv
module imu_fast_path #(
  parameter int DW = 16
) (
  input  logic [2:0]      op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output logic            carry,
  output logic            ovf,
  output logic            mreg_we,
  output logic [2*DW-1:0] prod
);
  import imu_pkg::*;

  localparam int MW = 2 * DW;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0]   sum_w;
  logic [DW:0]   dif_w;
  logic [MW-1:0] ext_a;
  logic [MW-1:0] ext_b;
  logic          mul_ovf;

  always_comb begin
    sum_w   = {1'b0, a} + {1'b0, b};
    dif_w   = {1'b0, a} - {1'b0, b};
    ext_a   = {{DW{a[DW-1]}}, a};
    ext_b   = {{DW{b[DW-1]}}, b};
    prod    = ext_a * ext_b;
    mul_ovf = (prod[MW-1:DW-1] != {(DW+1){1'b0}}) &&
              (prod[MW-1:DW-1] != {(DW+1){1'b1}});
  end

  always_comb begin
    res     = '0;
    carry   = 1'b0;
    ovf     = 1'b0;
    mreg_we = 1'b0;
    unique case (op)
      OP_ADD: begin
        res   = sum_w[DW-1:0];
        carry = sum_w[DW];
        ovf   = (a[DW-1] == b[DW-1]) && (sum_w[DW-1] != a[DW-1]);
      end
      OP_SUB: begin
        res   = dif_w[DW-1:0];
        carry = dif_w[DW];
        ovf   = (a[DW-1] != b[DW-1]) && (dif_w[DW-1] != a[DW-1]);
      end
      OP_MUL: begin
        mreg_we = 1'b1;
        ovf     = mul_ovf;
        res     = mul_ovf ? (prod[MW-1] ? SMIN : SMAX) : prod[DW-1:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/imu_divider.sv
module imu_divider #(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [2*DW-1:0]           dvd,
  input  logic [DW:0]               dvs,
  input  logic [$clog2(2*DW)-1:0]   iters,
  output logic                      last,
  output logic [2*DW-1:0]           quo,
  output logic [DW:0]               rem,
  output logic [DW:0]               dvs_o
);
  localparam int MW = 2 * DW;
  localparam int CW = $clog2(MW);

  logic [MW-1:0] quo_q, quo_n;
  logic [DW:0]   rem_q, rem_n;
  logic [DW:0]   dvs_q, dvs_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n;
  logic [DW+1:0] shifted;
  logic [DW+1:0] trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[MW-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = !trial[DW+1];
    quo_n   = quo_q;
    rem_n   = rem_q;
    dvs_n   = dvs_q;
    cnt_n   = cnt_q;
    run_n   = run_q;
    if (load) begin
      quo_n = dvd;
      rem_n = '0;
      dvs_n = dvs;
      cnt_n = iters;
      run_n = 1'b1;
    end else if (run_q) begin
      quo_n = {quo_q[MW-2:0], fits};
      rem_n = fits ? trial[DW:0] : shifted[DW:0];
      if (cnt_q == '0) run_n = 1'b0;
      else             cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (load || run_q) begin
        quo_q <= quo_n;
        rem_q <= rem_n;
        cnt_q <= cnt_n;
      end
      if (load) dvs_q <= dvs_n;
      run_q <= run_n;
    end
  end

  assign last  = run_q && (cnt_q == '0);
  assign quo   = quo_q;
  assign rem   = rem_q;
  assign dvs_o = dvs_q;

  // R9: a zero divisor never reaches the iteration engine
  p_nonzero_divisor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (dvs != '0));

  // R6: partial remainder always below the divisor magnitude while running
  p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q < dvs_q));

  // R11: a running sequence is not restarted
  p_no_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !load);

endmodule

// File: rtl/imu_div_post.sv
module imu_div_post #(
  parameter int DW = 16
) (
  input  logic            is_ddv,
  input  logic            neg_q,
  input  logic            neg_r,
  input  logic [2*DW-1:0] quo,
  input  logic [DW:0]     rem,
  input  logic [DW:0]     dvs,
  output logic [DW-1:0]   dest,
  output logic [DW-1:0]   q_word,
  output logic [DW-1:0]   r_word,
  output logic            ovf
);
  localparam int MW = 2 * DW;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [MW-1:0] LIM_POS = {{DW{1'b0}}, SMAX};
  localparam logic [MW-1:0] LIM_NEG = {{DW{1'b0}}, SMIN};

  logic [DW-1:0] q_mag;
  logic [DW-1:0] q_rnd;
  logic          half_up;

  always_comb begin
    ovf     = neg_q ? (quo > LIM_NEG) : (quo > LIM_POS);
    q_mag   = quo[DW-1:0];
    q_word  = neg_q ? (~q_mag + 1'b1) : q_mag;
    r_word  = neg_r ? (~rem[DW-1:0] + 1'b1) : rem[DW-1:0];
    half_up = !is_ddv && ({rem, 1'b0} >= {1'b0, dvs});
    q_rnd   = q_mag + {{(DW-1){1'b0}}, half_up};
    if (ovf)        dest = neg_q ? SMIN : SMAX;
    else if (neg_q) dest = ~q_rnd + 1'b1;
    else            dest = q_rnd;
  end

endmodule

// File: rtl/int_math_unit.sv
module int_math_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic          err_clr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] dest,
  output logic [DW-1:0] mreg_hi,
  output logic [DW-1:0] mreg_lo,
  output logic          flag_c,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_s,
  output logic          minor_err
);
  import imu_pkg::*;

  localparam int MW = 2 * DW;
  localparam int CW = $clog2(MW);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NSAT = {1'b1, {(DW-2){1'b0}}, 1'b1};

  // reset synchronizer: asynchronous assertion, synchronous release
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  imu_state_e    state_q, state_n;
  imu_op_e       op_q, op_n;
  logic          negq_q, negq_n, negr_q, negr_n;
  logic [DW-1:0] dest_q, dest_n, mhi_q, mhi_n, mlo_q, mlo_n;
  logic          c_q, c_n, v_q, v_n, z_q, z_n, s_q, s_n;
  logic          err_q, err_n, done_q, done_n;
  logic          res_en, mreg_en;

  logic [DW-1:0] fp_res;
  logic          fp_c, fp_v, fp_mwe;
  logic [MW-1:0] fp_prod;

  logic          div_load, div_last;
  logic [MW-1:0] div_dvd, div_quo;
  logic [DW:0]   div_dvs, div_rem, div_dvs_q;
  logic [CW-1:0] div_iters;

  logic [DW-1:0] pp_dest, pp_q, pp_r;
  logic          pp_v;

  logic [DW:0]   ext_a, ext_b, mag_a, mag_b;
  logic [MW-1:0] mreg_cat, mag_m;
  logic          a_neg, b_neg, m_neg, accept;

  imu_fast_path #(.DW(DW)) u_fast (
    .op(op_code), .a(src_a), .b(src_b),
    .res(fp_res), .carry(fp_c), .ovf(fp_v), .mreg_we(fp_mwe), .prod(fp_prod)
  );

  imu_divider #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n_s), .load(div_load), .dvd(div_dvd), .dvs(div_dvs),
    .iters(div_iters), .last(div_last), .quo(div_quo), .rem(div_rem),
    .dvs_o(div_dvs_q)
  );

  imu_div_post #(.DW(DW)) u_post (
    .is_ddv(op_q == OP_DDV), .neg_q(negq_q), .neg_r(negr_q),
    .quo(div_quo), .rem(div_rem), .dvs(div_dvs_q),
    .dest(pp_dest), .q_word(pp_q), .r_word(pp_r), .ovf(pp_v)
  );

  // operand magnitudes
  always_comb begin
    a_neg    = src_a[DW-1];
    b_neg    = src_b[DW-1];
    ext_a    = {src_a[DW-1], src_a};
    ext_b    = {src_b[DW-1], src_b};
    mag_a    = a_neg ? (~ext_a + 1'b1) : ext_a;
    mag_b    = b_neg ? (~ext_b + 1'b1) : ext_b;
    mreg_cat = {mhi_q, mlo_q};
    m_neg    = mreg_cat[MW-1];
    mag_m    = m_neg ? (~mreg_cat + 1'b1) : mreg_cat;
    accept   = start && (state_q == ST_IDLE) && (op_code <= OP_LAST);
  end

  // next-state logic
  always_comb begin
    state_n   = state_q;
    op_n      = op_q;
    negq_n    = negq_q;
    negr_n    = negr_q;
    dest_n    = dest_q;
    mhi_n     = mhi_q;
    mlo_n     = mlo_q;
    c_n       = c_q;
    v_n       = v_q;
    done_n    = 1'b0;
    mreg_en   = 1'b0;
    div_load  = 1'b0;
    div_dvd   = '0;
    div_dvs   = '0;
    div_iters = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          op_n = imu_op_e'(op_code);
          unique case (imu_op_e'(op_code))
            OP_DIV: begin
              if (src_b == '0) begin
                dest_n = a_neg ? NSAT : SMAX;
                c_n    = 1'b0;
                v_n    = 1'b1;
                done_n = 1'b1;
              end else begin
                div_load  = 1'b1;
                div_dvd   = {mag_a[DW-1:0], {DW{1'b0}}};
                div_dvs   = mag_b;
                div_iters = CW'(DW - 1);
                negq_n    = a_neg ^ b_neg;
                negr_n    = a_neg;
                state_n   = ST_RUN;
              end
            end
            OP_DDV: begin
              if (src_a == '0) begin
                dest_n = m_neg ? NSAT : SMAX;
                c_n    = 1'b0;
                v_n    = 1'b1;
                done_n = 1'b1;
              end else begin
                div_load  = 1'b1;
                div_dvd   = mag_m;
                div_dvs   = mag_a;
                div_iters = CW'(MW - 1);
                negq_n    = m_neg ^ a_neg;
                negr_n    = m_neg;
                state_n   = ST_RUN;
              end
            end
            default: begin
              dest_n  = fp_res;
              c_n     = fp_c;
              v_n     = fp_v;
              done_n  = 1'b1;
              mreg_en = fp_mwe;
              mhi_n   = fp_prod[MW-1:DW];
              mlo_n   = fp_prod[DW-1:0];
            end
          endcase
        end
      end
      ST_RUN: begin
        if (div_last) state_n = ST_FIN;
      end
      ST_FIN: begin
        dest_n  = pp_dest;
        c_n     = 1'b0;
        v_n     = pp_v;
        done_n  = 1'b1;
        mreg_en = !pp_v;
        mhi_n   = pp_q;
        mlo_n   = pp_r;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
    res_en = done_n;
    z_n    = (dest_n == '0);
    s_n    = dest_n[DW-1];
    if (done_n && v_n) err_n = 1'b1;
    else if (err_clr)  err_n = 1'b0;
    else               err_n = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ADD;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      dest_q  <= '0;
      mhi_q   <= '0;
      mlo_q   <= '0;
      c_q     <= 1'b0;
      v_q     <= 1'b0;
      z_q     <= 1'b0;
      s_q     <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      err_q   <= err_n;
      if (accept) begin
        op_q   <= op_n;
        negq_q <= negq_n;
        negr_q <= negr_n;
      end
      if (res_en) begin
        dest_q <= dest_n;
        c_q    <= c_n;
        v_q    <= v_n;
        z_q    <= z_n;
        s_q    <= s_n;
      end
      if (mreg_en) begin
        mhi_q <= mhi_n;
        mlo_q <= mlo_n;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign dest      = dest_q;
  assign mreg_hi   = mhi_q;
  assign mreg_lo   = mlo_q;
  assign flag_c    = c_q;
  assign flag_v    = v_q;
  assign flag_z    = z_q;
  assign flag_s    = s_q;
  assign minor_err = err_q;

  // R1: unknown operation codes start nothing
  p_bad_op_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && start && (op_code > OP_LAST)) |=> (!done && !busy));

  // R4: zero and negative never reported together
  p_zero_sign_excl_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !(flag_z && flag_s));

  // R5: multiply never reports a carry
  p_mul_nocarry_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && op_q == OP_MUL) |-> !flag_c);

  // R6: divisions never report a carry
  p_div_nocarry_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && (op_q == OP_DIV || op_q == OP_DDV)) |-> !flag_c);

  // R10: overflow completion leaves the error bit set
  p_ovf_sets_err_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && flag_v) |-> minor_err);

  // R10: error bit holds without a clear
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (minor_err && !err_clr) |=> minor_err);

  // R11: completion only while idle
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !busy);

  // R11: a running divide is never abandoned
  p_run_not_aborted_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_RUN) |=> (state_q != ST_IDLE));

endmodule

// File: tb/int_math_unit_bench.sv
`timescale 1ns/1ps
module int_math_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [15:0] src_a = '0;
  logic [15:0] src_b = '0;
  logic        err_clr = 1'b0;
  logic        busy, done, flag_c, flag_v, flag_z, flag_s, minor_err;
  logic [15:0] dest, mreg_hi, mreg_lo;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  int_math_unit u_int_math_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .err_clr(err_clr), .busy(busy), .done(done),
    .dest(dest), .mreg_hi(mreg_hi), .mreg_lo(mreg_lo), .flag_c(flag_c),
    .flag_v(flag_v), .flag_z(flag_z), .flag_s(flag_s), .minor_err(minor_err)
  );

  // layout: op[84:82] a[81:66] b[65:50] dest[49:34] c[33] v[32] mhi[31:16] mlo[15:0]
  localparam int NV = 26;
  localparam logic [84:0] VEC [0:NV-1] = '{
    {3'd0, 16'h1234, 16'h1111, 16'h2345, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {3'd0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 16'h0000, 16'h0000},
    {3'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {3'd1, 16'h0005, 16'h0007, 16'hFFFE, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {3'd1, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 1'b1, 16'h0000, 16'h0000},
    {3'd2, 16'h012C, 16'h00C8, 16'h7FFF, 1'b0, 1'b1, 16'h0000, 16'hEA60},
    {3'd2, 16'hFFFD, 16'h0007, 16'hFFEB, 1'b0, 1'b0, 16'hFFFF, 16'hFFEB},
    {3'd2, 16'h8000, 16'h8000, 16'h7FFF, 1'b0, 1'b1, 16'h4000, 16'h0000},
    {3'd4, 16'h7FFF, 16'h0000, 16'h7FFF, 1'b0, 1'b1, 16'h4000, 16'h0000},
    {3'd4, 16'hC000, 16'h0000, 16'h8000, 1'b0, 1'b1, 16'h4000, 16'h0000},
    {3'd2, 16'h03E8, 16'h03E8, 16'h7FFF, 1'b0, 1'b1, 16'h000F, 16'h4240},
    {3'd4, 16'h0064, 16'h0000, 16'h2710, 1'b0, 1'b0, 16'h2710, 16'h0000},
    {3'd2, 16'hFB2E, 16'h0038, 16'h8000, 1'b0, 1'b1, 16'hFFFE, 16'hF210},
    {3'd4, 16'h0005, 16'h0000, 16'hCA04, 1'b0, 1'b0, 16'hCA04, 16'hFFFC},
    {3'd3, 16'h0007, 16'h0002, 16'h0004, 1'b0, 1'b0, 16'h0003, 16'h0001},
    {3'd3, 16'hFFF9, 16'h0002, 16'hFFFC, 1'b0, 1'b0, 16'hFFFD, 16'hFFFF},
    {3'd3, 16'h0007, 16'h0003, 16'h0002, 1'b0, 1'b0, 16'h0002, 16'h0001},
    {3'd3, 16'h0064, 16'hFFF9, 16'hFFF2, 1'b0, 1'b0, 16'hFFF2, 16'h0002},
    {3'd3, 16'h8000, 16'hFFFF, 16'h7FFF, 1'b0, 1'b1, 16'hFFF2, 16'h0002},
    {3'd3, 16'h8000, 16'h0001, 16'h8000, 1'b0, 1'b0, 16'h8000, 16'h0000},
    {3'd3, 16'h0005, 16'h0000, 16'h7FFF, 1'b0, 1'b1, 16'h8000, 16'h0000},
    {3'd3, 16'hFFFB, 16'h0000, 16'h8001, 1'b0, 1'b1, 16'h8000, 16'h0000},
    {3'd4, 16'h0000, 16'h0000, 16'h8001, 1'b0, 1'b1, 16'h8000, 16'h0000},
    {3'd3, 16'h0000, 16'h0005, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {3'd4, 16'h0003, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {3'd3, 16'h7FFF, 16'h8000, 16'hFFFF, 1'b0, 1'b0, 16'h0000, 16'h7FFF}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // pulse start for one cycle, then wait for done; lat counts edges from the start edge
  task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic clr, output int lat);
    @(negedge clk);
    start = 1'b1; op_code = op; src_a = a; src_b = b; err_clr = clr;
    @(negedge clk);
    start = 1'b0; err_clr = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int lat;
    string tag;
    logic [2:0]  vop;
    logic [15:0] va, vb, ed, emh, eml;
    logic        ec, ev;
    int          elat;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    check("R12 reset outputs",
          {8'h0, dest, mreg_hi, mreg_lo, 1'b0, busy, done, flag_c, flag_v, flag_z, flag_s, minor_err},
          64'h0);

    for (int i = 0; i < NV; i++) begin
      {vop, va, vb, ed, ec, ev, emh, eml} = VEC[i];
      case (vop)
        3'd0: tag = "R2";
        3'd1: tag = "R3";
        3'd2: tag = "R5";
        3'd3: tag = ((vb == 16'h0) ? "R9" : (ev ? "R7" : "R6"));
        default: tag = ((va == 16'h0) ? "R9" : "R8");
      endcase
      if (vop == 3'd3 && vb != 16'h0)      elat = 18;
      else if (vop == 3'd4 && va != 16'h0) elat = 34;
      else                                 elat = 1;
      run_op(vop, va, vb, 1'b0, lat);
      check($sformatf("%s/R4 vec%0d dest,c,v,z,s", tag, i),
            {44'h0, dest, flag_c, flag_v, flag_z, flag_s},
            {44'h0, ed, ec, ev, (ed == 16'h0), ed[15]});
      check($sformatf("%s vec%0d math register", tag, i),
            {32'h0, mreg_hi, mreg_lo}, {32'h0, emh, eml});
      check($sformatf("%s/R13 vec%0d latency", (elat == 1) ? "R13" : tag, i),
            64'(lat), 64'(elat));
      @(negedge clk);
      check($sformatf("R13 vec%0d done pulse width", i), {63'h0, done}, 64'h0);
    end

    // R1: unused opcodes have no effect (dest FFFF, mreg 0000_7FFF from last vector)
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      start = 1'b1; op_code = 3'(k); src_a = 16'h0001; src_b = 16'h0001;
      @(negedge clk);
      start = 1'b0;
      check($sformatf("R1 op%0d no done/busy", k), {62'h0, done, busy}, 64'h0);
      @(negedge clk);
      check($sformatf("R1 op%0d state kept", k),
            {16'h0, dest, mreg_hi, mreg_lo}, {16'h0, 16'hFFFF, 16'h0000, 16'h7FFF});
    end

    // R10: sticky error bit, set since earlier overflows
    check("R10 error sticky across clean ops", {63'h0, minor_err}, 64'h1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R10 error cleared", {63'h0, minor_err}, 64'h0);
    run_op(3'd0, 16'h0001, 16'h0001, 1'b0, lat);
    check("R10 clean add keeps error low", {47'h0, dest, minor_err}, {47'h0, 16'h0002, 1'b0});
    run_op(3'd0, 16'h7FFF, 16'h7FFF, 1'b1, lat);
    check("R10 set wins over clear", {62'h0, flag_v, minor_err}, 64'h3);
    repeat (3) @(negedge clk);
    check("R10 holds without clear", {63'h0, minor_err}, 64'h1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R10 cleared when idle", {63'h0, minor_err}, 64'h0);

    // R11: start during a divide is ignored
    wait_idle();
    @(negedge clk);
    start = 1'b1; op_code = 3'd3; src_a = 16'h0064; src_b = 16'h0007;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 busy during divide", {62'h0, busy, done}, 64'h2);
    start = 1'b1; op_code = 3'd0; src_a = 16'h0001; src_b = 16'h0001;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check("R11 divide latency unaffected", 64'(lat), 64'd18);
    check("R11 divide result kept",
          {15'h0, busy, dest, mreg_hi, mreg_lo}, {15'h0, 1'b0, 16'h000E, 16'h000E, 16'h0002});
    repeat (3) begin
      @(negedge clk);
      check("R11 no extra completion", {47'h0, done, dest}, {47'h0, 1'b0, 16'h000E});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule